// File: doc/BRIEF.md
# Serial EEPROM Word Reader with Automatic Size Detection

This block is the master side of a four-wire serial EEPROM link of the Microwire kind. It drives chip select, the serial clock and the serial data line towards the memory, and samples the memory's data output. Each access fetches one 16-bit word. Two memory sizes can be fitted: a 1024-bit part holding 64 words, which takes 6 address bits, and a 4096-bit part holding 256 words, which takes 8.

After reset the block works out which part is fitted, with no help from software. It starts a read of word 0 and shifts address zeros out one at a time. A small part answers with its zero marker bit once it has 6 address bits; a large part only answers after 8. The result is shown on a status output. From then on, host reads go through a level request with a one-cycle acknowledge, and every read frame uses the address length of the detected part.

The serial clock is the system clock divided by a parameter, so the clock rate can be held at or below 1 MHz whatever the system clock is.

Top module: `mw_eeprom_reader`

## Requirements
- R1: While reset is held and right after it, `mw_cs`, `mw_sk`, `mw_di`, `ack` and `busy` are all 0.
- R2: Each high level of `mw_sk` lasts exactly `HALF_DIV` clock cycles. Inside a frame, each low level lasts at least `HALF_DIV` cycles. `mw_sk` is low whenever `mw_cs` is low.
- R3: `mw_di` changes only while `mw_sk` is low, that is, at a falling edge or at a chip-select edge. `mw_do` is sampled at the end of each low phase, at the rising edge. The memory is expected to update `mw_do` after falling edges.
- R4: Detection runs after reset. It sends a frame of start bit 1, opcode bits 1 then 0, and address zeros. In that frame, clock slot 0 is the start bit.
  - If `mw_do` is 0 when slot 9 is sampled (the slot after 6 address bits), `size_large` becomes 0.
  - Otherwise, if `mw_do` is 0 when slot 11 is sampled (the slot after 8 address bits), `size_large` becomes 1.
- R5: If `mw_do` is still 1 at slot 11 of the detection frame, `detect_err` becomes 1 and `size_large` becomes 0.
- R6: A request is neither accepted nor acknowledged until the detection frame and its chip-select gap have finished. `busy` stays 0 during that time.
- R7: A read frame is built as follows:
  - It sends 1, 1, 0, then the address MSB first, with 8 bits if `size_large` is 1 and 6 bits otherwise.
  - The next slot is the zero marker and is not stored.
  - It then captures 16 data bits MSB first.
  - The word appears on `rdata` in the same cycle that `ack` is 1.
- R8: When `size_large` is 0, `addr[7:6]` has no effect on the frame or on the returned word.
- R9: The following hold for the handshake:
  - `busy` rises in the cycle after a request is accepted.
  - `busy` is 1 until the acknowledge and is 0 in the cycle `ack` is 1.
  - `ack` lasts exactly one cycle.
- R10: Between any two frames, `mw_cs` stays low for at least 2×`HALF_DIV` cycles, which is one full clock period.
- R11: `req` and `addr` are sampled only when the block is idle. Changing `addr` during a frame does not change the word returned. The host drops `req` in the cycle where it sees `ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 1 | Read request level, held until ack |
| addr | input | 8 | Word address (bits 7:6 ignored for the small part) |
| ack | output | 1 | One-cycle read completion pulse |
| rdata | output | 16 | Word returned by the last read |
| busy | output | 1 | A host read is in progress |
| size_large | output | 1 | 0 = 64-word part, 1 = 256-word part |
| detect_err | output | 1 | No zero marker seen during detection |
| mw_cs | output | 1 | Memory chip select |
| mw_sk | output | 1 | Memory serial clock |
| mw_di | output | 1 | Serial data towards the memory |
| mw_do | input | 1 | Serial data from the memory (pulled high when idle) |

## Verification
The bench builds the block with `HALF_DIV` = 2, so a whole read frame takes only about a hundred system clocks. This makes it affordable to read every one of the 256 addresses against both a small and a large behavioural memory model. The same short divider makes the detection path cheap enough to run three times, once for each model: small part, large part, and no part at all. That brings the detect-error default, the held-off first request and the upper-address masking within reach in a single run.

// File: rtl/mw_eeprom_reader.sv
module mw_eeprom_reader #(
  parameter int HALF_DIV = 125
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req,
  input  logic [7:0]  addr,
  output logic        ack,
  output logic [15:0] rdata,
  output logic        busy,
  output logic        size_large,
  output logic        detect_err,
  output logic        mw_cs,
  output logic        mw_sk,
  output logic        mw_di,
  input  logic        mw_do
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [4:0] DET_SMALL_SLOT = 5'd9;
  localparam logic [4:0] DET_LARGE_SLOT = 5'd11;

  typedef enum logic [1:0] {S_IDLE, S_DET, S_RD, S_GAP} st_t;

  st_t           st;
  logic [CW-1:0] div;
  logic [4:0]    slot;
  logic [10:0]   tx;
  logic [15:0]   rx;
  logic          det_done, last, gap_n;

  wire       tick = (div == CW'(HALF_DIV - 1));
  wire [4:0] nab  = size_large ? 5'd8 : 5'd6;

  assign mw_di = mw_cs & tx[10];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;  div <= '0;  slot <= '0;  tx <= '0;  rx <= '0;
      rdata <= '0;  ack <= 1'b0;  busy <= 1'b0;  size_large <= 1'b0;
      detect_err <= 1'b0;  det_done <= 1'b0;  last <= 1'b0;  gap_n <= 1'b0;
      mw_cs <= 1'b0;  mw_sk <= 1'b0;
    end else begin
      ack <= 1'b0;
      div <= (st == S_IDLE || tick) ? '0 : div + 1'b1;
      case (st)
        S_IDLE: begin
          slot  <= '0;
          last  <= 1'b0;
          gap_n <= 1'b0;
          if (!det_done) begin
            mw_cs <= 1'b1;
            tx    <= 11'b110_0000_0000;
            st    <= S_DET;
          end else if (req) begin
            mw_cs <= 1'b1;
            busy  <= 1'b1;
            tx    <= size_large ? {3'b110, addr} : {3'b110, addr[5:0], 2'b00};
            st    <= S_RD;
          end
        end
        S_DET, S_RD: if (tick) begin
          if (!mw_sk) begin
            mw_sk <= 1'b1;
            if (st == S_DET) begin
              if (slot == DET_SMALL_SLOT && !mw_do) begin
                last <= 1'b1;
                size_large <= 1'b0;
              end else if (slot == DET_LARGE_SLOT) begin
                last <= 1'b1;
                size_large <= !mw_do;
                detect_err <= mw_do;
              end
            end else begin
              if (slot >= nab + 5'd4) rx <= {rx[14:0], mw_do};
              if (slot == nab + 5'd19) last <= 1'b1;
            end
          end else begin
            mw_sk <= 1'b0;
            slot  <= slot + 1'b1;
            tx    <= {tx[9:0], 1'b0};
            if (last) begin
              mw_cs <= 1'b0;
              st    <= S_GAP;
            end
          end
        end
        S_GAP: if (tick) begin
          gap_n <= 1'b1;
          if (gap_n) begin
            st <= S_IDLE;
            if (!det_done) det_done <= 1'b1;
            else begin
              ack   <= 1'b1;
              busy  <= 1'b0;
              rdata <= rx;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  logic [31:0] hi_cnt, lo_cnt;
  logic        had_frame;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt <= '0;  lo_cnt <= '0;  had_frame <= 1'b0;
    end else begin
      hi_cnt <= mw_sk ? hi_cnt + 1 : '0;
      lo_cnt <= mw_cs ? '0 : lo_cnt + 1;
      if (!mw_cs && had_frame == 1'b0 && det_done) had_frame <= 1'b1;
      else if (mw_cs) had_frame <= 1'b1;
    end
  end

  AST_SK_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n) mw_sk |-> mw_cs); // R2
  AST_SK_HIGH_LEN: assert property (@(posedge clk) disable iff (!rst_n) $fell(mw_sk) |-> hi_cnt == 32'(HALF_DIV)); // R2
  AST_DI_HOLD: assert property (@(posedge clk) disable iff (!rst_n) mw_sk |-> $stable(mw_di)); // R3
  AST_ERR_SMALL: assert property (@(posedge clk) disable iff (!rst_n) detect_err |-> !size_large); // R5
  AST_HOLDOFF: assert property (@(posedge clk) disable iff (!rst_n) !det_done |-> !busy && !ack); // R6
  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n) ack |=> !ack); // R9
  AST_ACK_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n) ack |-> !busy && $past(busy)); // R9
  AST_CS_GAP: assert property (@(posedge clk) disable iff (!rst_n) ($rose(mw_cs) && had_frame) |-> lo_cnt >= 32'(2 * HALF_DIV)); // R10
endmodule

// File: tb/mw_eeprom_reader_test.sv
module mw_eeprom_reader_test;
  localparam int H = 2;

  logic clk = 0, rst_n = 0, req = 0;
  logic [7:0] addr = 0;
  logic ack, busy, size_large, detect_err, mw_cs, mw_sk, mw_di, mw_do;
  logic [15:0] rdata;

  always #2 clk = ~clk;

  mw_eeprom_reader #(.HALF_DIV(H)) uut (
    .clk(clk), .rst_n(rst_n), .req(req), .addr(addr), .ack(ack), .rdata(rdata),
    .busy(busy), .size_large(size_large), .detect_err(detect_err),
    .mw_cs(mw_cs), .mw_sk(mw_sk), .mw_di(mw_di), .mw_do(mw_do));

  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  // memory model: 0 = small part, 1 = large part, 2 = absent
  int mode = 0;
  int bcnt = 0, k = 0;
  logic do_r = 1'b1;
  logic [7:0] dev_a = 0, last_a = 0;
  logic [2:0] dev_cmd = 0, last_cmd = 0;
  logic [15:0] w;
  assign mw_do = do_r;

  function automatic logic [15:0] mem(input int a);
    return 16'(a * 40503) ^ 16'(a << 7) ^ 16'h3C5A;
  endfunction
  function automatic int abits();
    return (mode == 1) ? 8 : 6;
  endfunction

  always @(posedge mw_sk or negedge mw_cs) begin
    if (!mw_cs) begin
      bcnt = 0; dev_a = 0; dev_cmd = 0;
    end else begin
      bcnt++;
      if (bcnt <= 3) dev_cmd = {dev_cmd[1:0], mw_di};
      else if (bcnt <= 3 + abits()) dev_a = {dev_a[6:0], mw_di};
      if (bcnt == 3 + abits()) begin last_a = dev_a; last_cmd = dev_cmd; end
    end
  end

  always @(negedge mw_sk or negedge mw_cs) begin
    if (!mw_cs) do_r = 1'b1;
    else if (mode != 2 && bcnt >= 3 + abits()) begin
      k = bcnt - 3 - abits();
      w = mem(int'(dev_a));
      if (k == 0) do_r = 1'b0;
      else if (k <= 16) do_r = w[16-k];
      else do_r = 1'b0;
    end
  end

  // port-level timing monitors
  int hi_run = 0, lo_run = 0, sk_bad = 0, di_bad = 0, gap_min = 1000000, cs_falls = 0;
  bit seen_fall = 0;
  logic prev_cs = 0, prev_sk = 0, prev_di = 0;
  always @(negedge clk) begin
    if (!rst_n) begin
      seen_fall = 0; cs_falls = 0; hi_run = 0; lo_run = 0;
    end else begin
      if (mw_sk) hi_run++;
      else begin
        if (hi_run != 0 && hi_run != H) sk_bad++;
        hi_run = 0;
      end
      if (!mw_cs && mw_sk) sk_bad++;
      if (mw_sk && prev_sk && mw_di != prev_di) di_bad++;
      if (mw_sk && !prev_sk && mw_di != prev_di) di_bad++;
      if (prev_cs && !mw_cs) begin cs_falls++; seen_fall = 1; end
      if (!mw_cs) lo_run++;
      else begin
        if (seen_fall && lo_run > 0 && lo_run < gap_min) gap_min = lo_run;
        lo_run = 0;
      end
    end
    prev_cs = mw_cs; prev_sk = mw_sk; prev_di = mw_di;
  end

  task automatic rd(input logic [7:0] a, input bit busy_chk, input bit swap, output logic [15:0] d);
    @(negedge clk); req = 1; addr = a;
    @(negedge clk);
    if (busy_chk) chk(busy == 1'b1, "R9 busy after accept", busy, 1);
    if (swap) addr = ~a;
    while (!ack) @(negedge clk);
    chk(busy == 1'b0, "R9 busy low at ack", busy, 0);
    d = rdata; req = 0;
    @(negedge clk);
    chk(ack == 1'b0, "R9 ack one cycle", ack, 0);
  endtask

  task automatic run_mode(input int m);
    logic [15:0] d, e;
    logic [7:0] am;
    mode = m;
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk({mw_cs, mw_sk, mw_di, ack, busy} == 5'b0, "R1 reset outputs", {mw_cs, mw_sk, mw_di, ack, busy}, 0);
    rst_n = 1;
    @(negedge clk); req = 1; addr = 8'h00;
    @(negedge clk);
    chk(busy == 1'b0, "R6 held off during detection", busy, 0);
    while (!ack) @(negedge clk);
    chk(cs_falls == 2, "R6 first ack after detection frame", cs_falls, 2);
    chk(size_large == (m == 1), "R4 size status", size_large, (m == 1));
    chk(detect_err == (m == 2), "R5 detect error", detect_err, (m == 2));
    req = 0;
    e = (m == 2) ? 16'hFFFF : mem(0);
    chk(rdata == e, "R7 first word", rdata, e);
    for (int a = 0; a < ((m == 2) ? 8 : 256); a++) begin
      rd(8'(a), 1, 0, d);
      am = (m == 1) ? 8'(a) : 8'(a & 63);
      e  = (m == 2) ? 16'hFFFF : mem(int'(am));
      chk(d == e, (m == 0 && a > 63) ? "R8 upper address bits ignored" : "R7 read word", d, e);
      chk(last_cmd == 3'b110, "R7 start and opcode", last_cmd, 3'b110);
      chk(last_a == am, (m == 0) ? "R8 six address bits" : "R7 eight address bits", last_a, am);
    end
    rd(8'h25, 1, 1, d);
    e = (m == 2) ? 16'hFFFF : mem(8'h25);
    chk(d == e, "R11 address changed mid-frame", d, e);
    repeat (4 * H + 4) @(negedge clk);
    chk(mw_cs == 1'b0, "R11 no new frame after ack", mw_cs, 0);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    chk({mw_cs, mw_sk, mw_di, ack, busy} == 5'b0, "R1 outputs under reset", {mw_cs, mw_sk, mw_di, ack, busy}, 0);
    chk(size_large == 1'b0 && detect_err == 1'b0, "R1 status under reset", {size_large, detect_err}, 0);
    for (int m = 0; m < 3; m++) run_mode(m);
    chk(sk_bad == 0, "R2 clock levels", sk_bad, 0);
    chk(di_bad == 0, "R3 data changes only with clock low", di_bad, 0);
    chk(gap_min >= 2 * H, "R10 chip-select gap", gap_min, 2 * H);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule